// File: doc/BRIEF.md
# Receive Elastic Buffer with Latency Status

This block decouples a stream of parallel receive words, arriving on a clock recovered from the line, from the local user clock that consumes them. Words are written into a dual-clock memory on the recovered clock and read out on the user clock. Both pointers cross between the domains as Gray codes. The number of words held is computed on the read side from the synchronised write pointer and the local read pointer.

That count is compared against a lower and an upper latency threshold. A registered three-bit code in the user clock domain reports whether the fill level is between the thresholds, under the lower one or over the upper one. Two further codes flag that a read found the buffer empty or that a write found it full. Both of these error codes stay set until the buffer is reset. After a reset the read side holds off until the fill level reaches the midpoint of the two thresholds, so the buffer starts with margin in both directions.

A static parameter removes the memory and turns the block into a single register stage on the user clock. An asynchronous reset input reinitialises both sides. It is released separately into each clock domain.

Top module: `rx_elastic_buf`

## Requirements
- R1: `status` is 3'b000 when the number of words held is at least MIN_LAT and at most MAX_LAT, and neither error code is pending.
- R2: `status` is 3'b001 when fewer than MIN_LAT words are held and neither error code is pending.
- R3: `status` is 3'b010 when more than MAX_LAT words are held and neither error code is pending.
- R4: A read request (`rd_en` high) after reading has begun, made while the buffer is empty, sets `status` to 3'b101. The code stays until reset unless an overflow replaces it, and the failed read produces no `rd_valid`.
- R5: A write request made while DEPTH words are held is dropped and sets `status` to 3'b110. That code stays until reset and takes priority over every other code. After it, exactly the DEPTH words held before the failed write are read out.
- R6: Every accepted word is delivered exactly once, in write order. `rd_data` is valid in the user clock cycle in which `rd_valid` is high, and each such cycle follows a read request made while words were held.
- R7: After reset, read requests are ignored until at least (MIN_LAT+MAX_LAT)/2 words are held. Ignored requests produce no data and no underflow code.
- R8: Asserting `buf_rst` empties the buffer, clears both error codes and drives `rd_valid` low. After release, `status` reads 3'b001.
- R9: With BYPASS=1, `rd_valid` and `rd_data` equal `wr_en` and `wr_data` sampled on the previous `rclk` edge, and `status` is 3'b000.
- R10: Elaboration is rejected unless MIN_LAT < MAX_LAT < DEPTH and DEPTH is a power of two.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Recovered receive clock, write side |
| rclk | input | 1 | Local user clock, read side |
| buf_rst | input | 1 | Asynchronous active-high buffer reset |
| wr_en | input | 1 | Write request for `wr_data` |
| wr_data | input | DATA_W | Receive word to store |
| rd_en | input | 1 | Read request from the user side |
| rd_data | output | DATA_W | Word delivered on the user clock |
| rd_valid | output | 1 | `rd_data` carries a delivered word |
| status | output | 3 | Fill and error code, user clock domain |

## Verification
The hardest state to reach from the ports is a fill level pinned exactly against a threshold while the pointers are still crossing clock domains, because the code reflects a view that trails the writes by several cycles. The stimulus runs the two clocks at slightly different periods and lets each direction go quiet before sampling the code. It walks the fill level through every band: hold-off, nominal, above the upper threshold, below the lower one, empty, an underflow and then an overflow on top of it. Constrained random traffic, throttled by a bench-side count of held words, then keeps the level moving between the thresholds while a scoreboard follows every delivered word.

// File: rtl/reb_pkg.sv
package reb_pkg;

  typedef enum logic [2:0] {
    STS_NOMINAL = 3'b000,
    STS_LOW     = 3'b001,
    STS_HIGH    = 3'b010,
    STS_UNDER   = 3'b101,
    STS_OVER    = 3'b110
  } reb_status_e;

endpackage

// File: rtl/reb_rst_sync.sv
// Reset bridge: asserts at once, releases on the local clock.
module reb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) chain_q <= '1;
    else      chain_q <= {chain_q[STAGES-2:0], 1'b0};
  end

  assign rst = chain_q[STAGES-1];

endmodule

// File: rtl/reb_gray_sync.sv
// Brings a Gray-coded value into another domain and returns it as binary.
module reb_gray_sync #(
  parameter int W      = 5,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);

  logic [W-1:0] stg_q [STAGES];

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= gray_in;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign bin_out = gray_to_bin(stg_q[STAGES-1]);

endmodule

// File: rtl/reb_dpram.sv
// Simple dual-port memory, one write clock, one read clock, registered read.
module reb_dpram #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int WORDS = 1 << AW;

  logic [DW-1:0] mem [WORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/reb_wr_ctl.sv
// Write side: pointer, full detection against the synchronised read pointer,
// sticky overflow flag.
module reb_wr_ctl #(
  parameter int AW    = 4,
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [AW:0] rptr_bin_s,
  output logic        we,
  output logic [AW-1:0] waddr,
  output logic [AW:0] wptr_gray,
  output logic        of_flag
);

  localparam int PW = AW + 1;

  logic [PW-1:0] wptr_bin;
  logic [PW-1:0] wptr_nxt;
  logic [PW-1:0] fill;
  logic          full;

  assign fill     = wptr_bin - rptr_bin_s;
  assign full     = (fill == PW'(DEPTH));
  assign we       = wr_en && !full;
  assign waddr    = wptr_bin[AW-1:0];
  assign wptr_nxt = wptr_bin + PW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_bin  <= '0;
      wptr_gray <= '0;
      of_flag   <= 1'b0;
    end else begin
      if (we) begin
        wptr_bin  <= wptr_nxt;
        wptr_gray <= wptr_nxt ^ (wptr_nxt >> 1);
      end
      if (wr_en && full) of_flag <= 1'b1;
    end
  end

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> $stable(wptr_bin)); // R5
  AST_OF_STICKY: assert property (@(posedge clk) disable iff (rst)
    of_flag |=> of_flag); // R5
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    fill <= PW'(DEPTH)); // R5

endmodule

// File: rtl/reb_rd_ctl.sv
// Read side: fill level, start hold-off, read pointer, sticky underflow,
// registered status code.
module reb_rd_ctl
  import reb_pkg::*;
#(
  parameter int AW        = 4,
  parameter int DEPTH     = 16,
  parameter int MIN_LAT   = 4,
  parameter int MAX_LAT   = 12,
  parameter int START_LVL = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic [AW:0]   wptr_bin_s,
  input  logic          of_s,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rptr_gray,
  output logic          rd_valid,
  output logic [2:0]    status
);

  localparam int PW = AW + 1;

  logic [PW-1:0] rptr_bin;
  logic [PW-1:0] rptr_nxt;
  logic [PW-1:0] occ;
  logic          started;
  logic          uf_q;
  logic          uf_hit;
  reb_status_e   sts_d;
  reb_status_e   sts_q;

  assign occ      = wptr_bin_s - rptr_bin;
  assign re       = started && rd_en && (occ != '0);
  assign uf_hit   = started && rd_en && (occ == '0);
  assign raddr    = rptr_bin[AW-1:0];
  assign rptr_nxt = rptr_bin + PW'(1);

  always_comb begin
    if (of_s)                      sts_d = STS_OVER;
    else if (uf_q || uf_hit)       sts_d = STS_UNDER;
    else if (occ < PW'(MIN_LAT))   sts_d = STS_LOW;
    else if (occ > PW'(MAX_LAT))   sts_d = STS_HIGH;
    else                           sts_d = STS_NOMINAL;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_bin  <= '0;
      rptr_gray <= '0;
      started   <= 1'b0;
      uf_q      <= 1'b0;
      rd_valid  <= 1'b0;
      sts_q     <= STS_LOW;
    end else begin
      if (!started && occ >= PW'(START_LVL)) started <= 1'b1;
      if (re) begin
        rptr_bin  <= rptr_nxt;
        rptr_gray <= rptr_nxt ^ (rptr_nxt >> 1);
      end
      if (uf_hit) uf_q <= 1'b1;
      rd_valid <= re;
      sts_q    <= sts_d;
    end
  end

  assign status = sts_q;

  AST_START_LEVEL: assert property (@(posedge clk) disable iff (rst)
    $rose(started) |-> (occ >= PW'(START_LVL))); // R7
  AST_UF_STICKY: assert property (@(posedge clk) disable iff (rst)
    uf_q |=> uf_q); // R4
  AST_OCC_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ <= PW'(DEPTH)); // R6
  AST_VALID_HAD_DATA: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_valid) |-> ($past(occ) != '0)); // R6

endmodule

// File: rtl/rx_elastic_buf.sv
module rx_elastic_buf #(
  parameter int DATA_W   = 16,
  parameter int DEPTH    = 16,
  parameter int MIN_LAT  = 4,
  parameter int MAX_LAT  = 12,
  parameter int SYNC_STG = 2,
  parameter bit BYPASS   = 1'b0
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              buf_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [2:0]        status
);

  localparam int AW        = $clog2(DEPTH);
  localparam int PW        = AW + 1;
  localparam int START_LVL = (MIN_LAT + MAX_LAT) / 2;

  // R10: threshold ordering and depth shape checked at elaboration
  if (!(MIN_LAT < MAX_LAT && MAX_LAT < DEPTH) || ((1 << AW) != DEPTH)) begin : g_bad_cfg
    $error("rx_elastic_buf: need MIN_LAT < MAX_LAT < DEPTH, DEPTH a power of two");
  end

  logic rst_r;

  reb_rst_sync #(.STAGES(SYNC_STG)) i_rst_rd (
    .clk(rclk), .arst(buf_rst), .rst(rst_r)
  );

  if (!BYPASS) begin : g_buf
    logic          rst_w;
    logic          we;
    logic          re;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [PW-1:0] wptr_gray;
    logic [PW-1:0] rptr_gray;
    logic [PW-1:0] wptr_bin_s;
    logic [PW-1:0] rptr_bin_s;
    logic          of_flag;
    logic          of_s;

    reb_rst_sync #(.STAGES(SYNC_STG)) i_rst_wr (
      .clk(wclk), .arst(buf_rst), .rst(rst_w)
    );

    reb_wr_ctl #(.AW(AW), .DEPTH(DEPTH)) i_wr (
      .clk(wclk), .rst(rst_w), .wr_en(wr_en), .rptr_bin_s(rptr_bin_s),
      .we(we), .waddr(waddr), .wptr_gray(wptr_gray), .of_flag(of_flag)
    );

    reb_gray_sync #(.W(PW), .STAGES(SYNC_STG)) i_wptr_sync (
      .clk(rclk), .rst(rst_r), .gray_in(wptr_gray), .bin_out(wptr_bin_s)
    );

    reb_gray_sync #(.W(PW), .STAGES(SYNC_STG)) i_rptr_sync (
      .clk(wclk), .rst(rst_w), .gray_in(rptr_gray), .bin_out(rptr_bin_s)
    );

    reb_gray_sync #(.W(1), .STAGES(SYNC_STG)) i_of_sync (
      .clk(rclk), .rst(rst_r), .gray_in(of_flag), .bin_out(of_s)
    );

    reb_dpram #(.DW(DATA_W), .AW(AW)) i_mem (
      .wclk(wclk), .we(we), .waddr(waddr), .wdata(wr_data),
      .rclk(rclk), .re(re), .raddr(raddr), .rdata(rd_data)
    );

    reb_rd_ctl #(
      .AW(AW), .DEPTH(DEPTH), .MIN_LAT(MIN_LAT), .MAX_LAT(MAX_LAT),
      .START_LVL(START_LVL)
    ) i_rd (
      .clk(rclk), .rst(rst_r), .rd_en(rd_en), .wptr_bin_s(wptr_bin_s),
      .of_s(of_s), .re(re), .raddr(raddr), .rptr_gray(rptr_gray),
      .rd_valid(rd_valid), .status(status)
    );

    AST_OVER_PRIORITY: assert property (@(posedge rclk) disable iff (rst_r)
      $rose(of_s) |=> (status == 3'b110)); // R5
  end else begin : g_byp
    always_ff @(posedge rclk) begin
      if (rst_r) rd_valid <= 1'b0;
      else       rd_valid <= wr_en;
      rd_data <= wr_data;
    end
    assign status = 3'b000;

    AST_BYP_FOLLOW: assert property (@(posedge rclk) disable iff (rst_r)
      wr_en |=> rd_valid); // R9
  end

endmodule

// File: tb/test_rx_elastic_buf.sv
`timescale 1ns/1ps
module test_rx_elastic_buf;

  localparam int DW    = 16;
  localparam int DEPTH = 16;
  localparam int MINL  = 4;
  localparam int MAXL  = 12;
  localparam int MID   = (MINL + MAXL) / 2;

  logic wclk = 1'b0;
  logic rclk = 1'b0;
  logic buf_rst = 1'b1;
  logic wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_valid;
  logic [2:0] status;

  logic b_wr_en = 1'b0;
  logic [DW-1:0] b_wr_data = '0;
  logic [DW-1:0] b_rd_data;
  logic b_rd_valid;
  logic [2:0] b_status;

  always #2   rclk = ~rclk;   // 250 MHz user clock
  always #2.1 wclk = ~wclk;   // recovered clock, slightly slower

  rx_elastic_buf #(.DATA_W(DW), .DEPTH(DEPTH), .MIN_LAT(MINL), .MAX_LAT(MAXL)) i_rx_elastic_buf (
    .wclk(wclk), .rclk(rclk), .buf_rst(buf_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid), .status(status)
  );

  rx_elastic_buf #(.DATA_W(DW), .DEPTH(DEPTH), .MIN_LAT(MINL), .MAX_LAT(MAXL), .BYPASS(1'b1)) i_rx_elastic_buf_byp (
    .wclk(wclk), .rclk(rclk), .buf_rst(buf_rst), .wr_en(b_wr_en), .wr_data(b_wr_data),
    .rd_en(1'b0), .rd_data(b_rd_data), .rd_valid(b_rd_valid), .status(b_status)
  );

  int n_run = 0;
  int n_fail = 0;
  int wr_cnt = 0;
  int rd_iss = 0;
  int vcount = 0;
  bit of_exp = 0;
  bit uf_exp = 0;
  logic [DW-1:0] sb[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int held();
    return wr_cnt - rd_iss;
  endfunction

  function automatic int exp_status(input int h, input bit ovf, input bit unf);
    if (ovf) return 3'b110;
    if (unf) return 3'b101;
    if (h < MINL) return 3'b001;
    if (h > MAXL) return 3'b010;
    return 3'b000;
  endfunction

  // scoreboard on delivered words (R6)
  always @(negedge rclk) begin
    if (rd_valid === 1'b1) begin
      vcount++;
      if (sb.size() == 0) chk(1'b0, "R6 extra word", int'(rd_data), -1);
      else begin
        logic [DW-1:0] e;
        e = sb.pop_front();
        chk(rd_data == e, "R6 order", int'(rd_data), int'(e));
      end
    end
  end

  task automatic wr_one(input bit req);
    @(negedge wclk);
    wr_en   = req;
    wr_data = DW'($urandom);
    if (req) begin
      if (held() < DEPTH) begin
        sb.push_back(wr_data);
        wr_cnt++;
      end else of_exp = 1'b1;
    end
  endtask

  task automatic wr_n(input int n);
    for (int i = 0; i < n; i++) wr_one(1'b1);
    @(negedge wclk) wr_en = 1'b0;
  endtask

  task automatic rd_n(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge rclk);
      rd_en = 1'b1;
      if (held() > 0) rd_iss++;
      else uf_exp = 1'b1;
    end
    @(negedge rclk) rd_en = 1'b0;
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic chk_sts(input string tag);
    chk(int'(status) == exp_status(held(), of_exp, uf_exp), tag,
        int'(status), exp_status(held(), of_exp, uf_exp));
  endtask

  task automatic do_reset();
    @(negedge rclk) buf_rst = 1'b1;
    wait_r(4);
    buf_rst = 1'b0;
    sb.delete();
    wr_cnt = 0; rd_iss = 0; of_exp = 0; uf_exp = 0;
    wait_r(10);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge rclk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    void'($urandom(32'h1bad5eed));
    wait_r(4);
    buf_rst = 1'b0;
    wait_r(10);

    // R8: state after reset
    chk(status == 3'b001, "R8 status after reset", int'(status), 1);
    chk(rd_valid == 1'b0, "R8 rd_valid after reset", int'(rd_valid), 0);

    // R7 / R1: hold-off below the start level
    wr_n(MID - 1);
    wait_r(20);
    chk_sts("R1 nominal at MID-1");
    @(negedge rclk) rd_en = 1'b1;
    wait_r(3);
    rd_en = 1'b0;
    wait_r(10);
    chk(vcount == 0, "R7 no data before start", vcount, 0);
    chk(status == 3'b000, "R7 ignored reads no underflow", int'(status), 0);
    wr_n(1);
    wait_r(20);
    rd_n(2);
    wait_r(10);
    chk(vcount == 2, "R7 reading began", vcount, 2);
    chk_sts("R1 nominal after start");

    // R3: above upper threshold
    wr_n(7);
    wait_r(20);
    chk(held() == MAXL + 1, "R3 bench fill", held(), MAXL + 1);
    chk_sts("R3 high");

    // R2: below lower threshold
    rd_n(10);
    wait_r(10);
    chk_sts("R2 low");
    chk(vcount == 12, "R6 delivered count", vcount, 12);

    // R4: underflow and its persistence
    rd_n(3);
    wait_r(10);
    chk_sts("R2 empty low");
    rd_n(1);
    wait_r(10);
    chk(status == 3'b101, "R4 underflow", int'(status), 5);
    chk(vcount == 15, "R4 no data on empty read", vcount, 15);
    wr_n(4);
    wait_r(20);
    chk(status == 3'b101, "R4 sticky", int'(status), 5);

    // R5: overflow drops, wins over underflow, stays
    wr_n(DEPTH - 4 + 3);
    wait_r(20);
    chk(status == 3'b110, "R5 overflow priority", int'(status), 6);
    rd_n(DEPTH + 2);
    wait_r(10);
    chk(vcount == 15 + DEPTH, "R5 only DEPTH words kept", vcount, 15 + DEPTH);
    chk(sb.size() == 0, "R5 scoreboard drained", sb.size(), 0);
    chk(status == 3'b110, "R5 sticky", int'(status), 6);

    // R8: reset clears errors
    do_reset();
    chk(status == 3'b001, "R8 status after buf_rst", int'(status), 1);
    chk(rd_valid == 1'b0, "R8 rd_valid after buf_rst", int'(rd_valid), 0);

    // R6 / R1: random traffic between the thresholds
    wr_n(MID);
    wait_r(20);
    fork
      begin
        for (int i = 0; i < 3000; i++) wr_one(($urandom % 4 != 0) && (held() < MAXL));
        @(negedge wclk) wr_en = 1'b0;
      end
      begin
        for (int i = 0; i < 3000; i++) begin
          @(negedge rclk);
          if (($urandom % 4 != 0) && (held() >= MINL + 3)) begin
            rd_en = 1'b1;
            rd_iss++;
          end else rd_en = 1'b0;
        end
        @(negedge rclk) rd_en = 1'b0;
      end
    join
    wait_r(20);
    chk_sts("R1 status after random traffic");
    rd_n(held());
    wait_r(10);
    chk(sb.size() == 0, "R6 all random words delivered", sb.size(), 0);
    chk_sts("R2 low after drain");

    // R9: bypass instance
    begin
      bit pe;
      logic [DW-1:0] pd;
      @(negedge rclk);
      b_wr_en = 1'b1; b_wr_data = 16'hA5C3;
      for (int i = 0; i < 40; i++) begin
        pe = b_wr_en; pd = b_wr_data;
        @(negedge rclk);
        chk(b_rd_valid == pe, "R9 valid follows", int'(b_rd_valid), int'(pe));
        if (pe) chk(b_rd_data == pd, "R9 data follows", int'(b_rd_data), int'(pd));
        chk(b_status == 3'b000, "R9 status", int'(b_status), 0);
        b_wr_en   = ($urandom % 3 != 0);
        b_wr_data = DW'($urandom);
      end
      b_wr_en = 1'b0;
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule